// File: doc/BRIEF.md
# Periodic Wake-Up Power Timer

This block sets the rhythm of a battery-powered field logger that stays unpowered almost all the time. It runs from a slow 2 Hz tick and counts those ticks in a 14-stage binary divider. A sparse set of divider outputs, stages 14, 13, 12 and 7, is combined into an all-ones test. When every one of those stages is high at once, the interval has elapsed. The block then emits a one-tick, active-low interval strobe. On the same edge it opens a power window of fixed length, and that window drives the relay that connects the battery to the acquisition electronics.

The divider returns to zero on the tick that completes the tap pattern. It never rolls over at its natural 16384-tick length, so the default spacing is exactly 14400 ticks, which is two hours at 2 Hz. The power window lasts 14 ticks, which is seven seconds. The tap mask, the divider width and the window length are parameters, so a short configuration can be used to exercise every behaviour quickly. An advance-enable input qualifies each tick. In normal use it is tied high, and a test fixture can drop it to stall the whole timer.

Top module: `wake_timer`

## Requirements
- R1: A clock edge with `rst_n` low clears the divider and closes the power window: `pwr_en` is 0 and `interval_n` is 1 after that edge, and the first strobe after release comes after exactly one full period of enabled ticks.
- R2: The period in enabled ticks equals the integer value of the tap mask. The default mask sets stage bits 13, 12, 11 and 6 (numbered from 0), which are stages 14, 13, 12 and 7, giving 14400 ticks.
- R3: `interval_n` is active low and goes low for exactly one clock after the edge that completes the tap pattern. It is high at all other times.
- R4: `pwr_en` rises on the same edge on which `interval_n` falls. It then stays high for exactly PULSE_TICKS enabled ticks, 14 by default.
- R5: The power window cannot be retriggered. A tap match while `pwr_en` is high, including its last tick, does not lengthen the window, and `pwr_en` falls at its original time. The strobe for that match still appears.
- R6: On an edge with `adv_en` low, the divider and the power window hold their state, `pwr_en` keeps its value, and `interval_n` is high after that edge.
- R7: The divider clears to zero on the matching tick and never passes the period value. With the defaults, exactly one strobe occurs in the first 14440 enabled ticks after reset, so none comes at the 16384-tick wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow base tick (2 Hz in the field) |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_en | input | 1 | Tick qualifier; low stalls divider and window |
| pwr_en | output | 1 | Power-window output driving the supply relay |
| interval_n | output | 1 | Active-low one-tick end-of-interval strobe |

## Verification
The hardest case to reach is a tap match that lands while a power window is still open. In the field configuration the window is thousands of ticks shorter than the period, so this never happens. The bench therefore also builds a second instance whose period (12 ticks) is shorter than its window (14 ticks), so every other match falls inside an open window. It then stalls that instance with an irregular enable pattern and resets it in the middle of a window. A behavioural model follows both instances tick by tick. The default instance is run past its full 14400-tick period to confirm the real spacing and the absence of a wrap.

// File: rtl/wake_timer_pkg.sv
// Package: shared defaults and types for the periodic wake-up timer.
// Assumes: the tap mask value is the period; callers keep it >= 2.
package wake_timer_pkg;
    localparam int                 WT_DEF_CW    = 14;
    localparam logic [WT_DEF_CW-1:0] WT_DEF_TAPS = 14'b11_1000_0100_0000;
    localparam int                 WT_DEF_PULSE = 14;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;
endpackage

// File: rtl/wake_divider.sv
// Module: wake_divider
// Binary tick divider with a sparse tap decode. The decode looks at the
// value the divider is about to take. When every tapped stage of that value
// is high, the divider loads zero instead and raises hit for that tick.
// Assumes: TAP_MASK has at least one bit set; adv_en qualifies every tick.
module wake_divider #(
    parameter int             CW       = 14,
    parameter logic [CW-1:0]  TAP_MASK = 14'b11_1000_0100_0000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_en,
    output logic hit
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] tap_ok;
    logic          taps_nand;

    // Incremented value examined by the tap decode.
    assign cnt_nxt = cnt_q + CW'(1);

    // Per-stage tap gating: untapped stages always pass.
    for (genvar gi = 0; gi < CW; gi++) begin : g_tap
        if (TAP_MASK[gi]) begin : g_used
            assign tap_ok[gi] = cnt_nxt[gi];
        end else begin : g_free
            assign tap_ok[gi] = 1'b1;
        end
    end

    // Active-low all-taps-high decode, qualified by the tick enable.
    assign taps_nand = ~(&tap_ok);
    assign hit       = adv_en & ~taps_nand;

    // Divider state: advance on enabled ticks, clear on a tap match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (adv_en) begin
            cnt_q <= taps_nand ? cnt_nxt : '0;
        end
    end
endmodule

// File: rtl/wake_oneshot.sv
// Module: wake_oneshot
// Fixed-length, non-retriggerable window. A trigger while idle opens the
// window for PULSE enabled ticks. Triggers while it is open are dropped.
// Assumes: PULSE >= 1; trig is already qualified by adv_en.
module wake_oneshot
    import wake_timer_pkg::*;
#(
    parameter int PULSE = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_en,
    input  logic trig,
    output logic pwr_en
);
    localparam int RW = (PULSE > 1) ? $clog2(PULSE) : 1;

    win_state_e    state_q;
    logic [RW-1:0] left_q;

    // Window sequencer: open on trigger, count down the remaining ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_IDLE;
            left_q  <= '0;
        end else if (adv_en) begin
            case (state_q)
                WIN_IDLE: begin
                    if (trig) begin
                        state_q <= WIN_OPEN;
                        left_q  <= RW'(PULSE - 1);
                    end
                end
                default: begin
                    if (left_q == '0) begin
                        state_q <= WIN_IDLE;
                    end else begin
                        left_q <= left_q - RW'(1);
                    end
                end
            endcase
        end
    end

    // Output decode of the window state.
    assign pwr_en = (state_q == WIN_OPEN);
endmodule

// File: rtl/wake_timer.sv
// Module: wake_timer (top)
// Periodic wake-up timer: the divider finds the interval end, a registered
// active-low strobe marks it, and a one-shot opens the power window.
// Assumes: clk is the slow base tick; the tap mask value is at least 2.
module wake_timer
    import wake_timer_pkg::*;
#(
    parameter int            CW          = WT_DEF_CW,
    parameter logic [CW-1:0] TAP_MASK    = WT_DEF_TAPS,
    parameter int            PULSE_TICKS = WT_DEF_PULSE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_en,
    output logic pwr_en,
    output logic interval_n
);
    logic hit;
    logic strobe_n_q;

    wake_divider #(
        .CW       (CW),
        .TAP_MASK (TAP_MASK)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_en (adv_en),
        .hit    (hit)
    );

    wake_oneshot #(
        .PULSE (PULSE_TICKS)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_en (adv_en),
        .trig   (hit),
        .pwr_en (pwr_en)
    );

    // Registered interval strobe, low for the one tick after a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_n_q <= 1'b1;
        end else begin
            strobe_n_q <= ~hit;
        end
    end

    assign interval_n = strobe_n_q;
endmodule

// File: rtl/wake_timer_chk.sv
// Module: wake_timer_chk
// Port-level checker for wake_timer. It keeps its own tick counters for the
// period and window windows instead of looking inside the design.
// Assumes: PERIOD >= 2 and PULSE >= 1.
module wake_timer_chk #(
    parameter int PERIOD = 14400,
    parameter int PULSE  = 14
) (
    input logic clk,
    input logic rst_n,
    input logic adv_en,
    input logic pwr_en,
    input logic interval_n
);
    int unsigned gap_q;
    int unsigned len_q;

    // Enabled ticks since reset or since the last observed strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= 0;
        end else if (!interval_n) begin
            gap_q <= adv_en ? 1 : 0;
        end else if (adv_en) begin
            gap_q <= gap_q + 1;
        end
    end

    // Enabled ticks seen while the power window is open.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_en) begin
            len_q <= 0;
        end else if (adv_en) begin
            len_q <= len_q + 1;
        end
    end

    assert_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !interval_n |-> gap_q == PERIOD);

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= PERIOD);

    assert_strobe_one_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !interval_n |=> interval_n);

    assert_rise_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> !interval_n);

    assert_window_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> len_q == PULSE);

    assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> (interval_n && $stable(pwr_en)));
endmodule

bind wake_timer wake_timer_chk #(
    .PERIOD (int'(TAP_MASK)),
    .PULSE  (PULSE_TICKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_en     (adv_en),
    .pwr_en     (pwr_en),
    .interval_n (interval_n)
);

// File: tb/wake_timer_bench.sv
// Bench: a default instance and a short fast instance, each followed by a
// behavioural tick model and compared on every clock.
module wake_timer_bench;
    localparam int FAST_PERIOD = 12;
    localparam int FAST_PULSE  = 14;
    localparam int DEF_PERIOD  = 14400;
    localparam int DEF_PULSE   = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_d = 1'b0;
    logic en_f = 1'b0;
    logic pwr_d, str_d, pwr_f, str_f;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string phase = "R1";

    int m_cnt [2];
    int m_rem [2];
    bit m_str [2];
    int t_d = 0;
    int def_strobes = 0;
    int def_strobe_at = -1;

    always #10 clk = ~clk;

    wake_timer u_wake_timer (
        .clk(clk), .rst_n(rst_n), .adv_en(en_d),
        .pwr_en(pwr_d), .interval_n(str_d)
    );

    wake_timer #(
        .CW(6), .TAP_MASK(6'b001100), .PULSE_TICKS(FAST_PULSE)
    ) u_wake_timer_fast (
        .clk(clk), .rst_n(rst_n), .adv_en(en_f),
        .pwr_en(pwr_f), .interval_n(str_f)
    );

    // Behavioural reference: tick counts, remaining window ticks.
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            automatic bit en  = (i == 0) ? en_d : en_f;
            automatic int per = (i == 0) ? DEF_PERIOD : FAST_PERIOD;
            automatic int pul = (i == 0) ? DEF_PULSE : FAST_PULSE;
            automatic bit hit = 1'b0;
            if (!rst_n) begin
                m_cnt[i] = 0; m_rem[i] = 0; m_str[i] = 1'b1;
            end else if (en) begin
                m_cnt[i] = m_cnt[i] + 1;
                if (m_cnt[i] == per) begin
                    hit = 1'b1; m_cnt[i] = 0;
                end
                m_str[i] = !hit;
                if (m_rem[i] == 0 && hit) m_rem[i] = pul;
                else if (m_rem[i] > 0) m_rem[i] = m_rem[i] - 1;
            end else begin
                m_str[i] = 1'b1;
            end
        end
        if (!rst_n) t_d = 0;
        else if (en_d) t_d = t_d + 1;
    end

    task automatic cmp(input string tag, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s (phase %s) %s got %0b expected %0b", tag, phase, what, got, exp);
        end
    endtask

    // One cycle: sample after the edge settles, at the falling edge.
    task automatic step();
        @(negedge clk);
        cmp("R3", "interval_n default", str_d, m_str[0]);
        cmp("R4", "pwr_en default", pwr_d, m_rem[0] > 0);
        cmp("R3", "interval_n fast", str_f, m_str[1]);
        cmp("R5", "pwr_en fast", pwr_f, m_rem[1] > 0);
        if (!str_d) begin
            def_strobes++;
            if (def_strobe_at < 0) def_strobe_at = t_d;
        end
    endtask

    initial begin
        // R1: reset state held for several edges.
        phase = "R1";
        repeat (3) step();
        cmp("R1", "pwr_en default in reset", pwr_d, 1'b0);
        cmp("R1", "interval_n fast in reset", str_f, 1'b1);

        // R2/R4: free running; fast period shorter than its window (R5).
        rst_n = 1'b1; en_d = 1'b1; en_f = 1'b1;
        phase = "R2";
        repeat (40) step();
        phase = "R5";
        repeat (40) step();

        // R6: irregular stalls on the fast instance only.
        phase = "R6";
        for (int k = 0; k < 60; k++) begin
            en_f = (k % 3 != 0) && (k % 7 != 5);
            step();
        end
        en_f = 1'b1;
        repeat (5) step();

        // R1: reset in the middle of a window.
        phase = "R1";
        while (!pwr_f) step();
        repeat (3) step();
        rst_n = 1'b0;
        repeat (2) step();
        cmp("R1", "pwr_en fast after mid-window reset", pwr_f, 1'b0);
        rst_n = 1'b1;
        def_strobes = 0; def_strobe_at = -1;

        // R7: full default period plus margin with no stall.
        phase = "R7";
        repeat (DEF_PERIOD + 40) step();
        checks++;
        if (def_strobe_at != DEF_PERIOD) begin
            errors++;
            $display("FAIL R2 first default strobe at tick %0d expected %0d", def_strobe_at, DEF_PERIOD);
        end
        checks++;
        if (def_strobes != 1) begin
            errors++;
            $display("FAIL R7 default strobes in window got %0d expected %0d", def_strobes, 1);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule